// File: doc/BRIEF.md
# Flash Error-Protection Status Register

This block is the 8-bit status register of an on-chip flash controller. Its top bit is a sticky error flag. The flag sets when an event that is not allowed takes place while a program or erase operation is running. Such an event is:

- a read of the flash array;
- the start of a qualifying exception;
- a sleep instruction;
- a release of the bus.

Software cannot clear the flag. Only a reset (from the pin or from the watchdog) or entry into hardware standby clears it. The other seven bits are plain read/write storage.

The block also protects the flash. Once the flag is set, a protection output rises one cycle later. While it is high, the protection output forces the program/erase-enable request towards the sequencer low. Reads are delivered through a registered data port. That port returns zero whenever the flash is disabled, and the stored state is kept while it does so.

Top module: `flash_err_guard`

## Requirements
- R1: After a cycle with `rst` or `hw_stby` high, `rdata` reads 0x00 within two cycles and `protect` is 0.
- R2: A write (`reg_we`) stores `wdata[6:0]` in bits 6..0. Those bits read back on `rdata[6:0]` two cycles after the write.
- R3: `wdata[7]` is ignored. Bit 7 of the register changes only through the error logic.
- R4: A cycle with `pe_active` and `rd_strobe` high sets the flag (bit 7), unless `rd_ram_overlap` is high in that cycle.
- R5: A cycle with `pe_active` and `exc_start` high sets the flag when `exc_code` is 4 or more. Codes 0 (reset), 1 (illegal instruction), 2 (trap) and 3 (divide by zero) do not set it.
- R6: A cycle with `pe_active` high together with `sleep_exec` or `bus_release` sets the flag.
- R7: While `pe_active` is low, none of the events in R4 to R6 changes the flag.
- R8: Once set, the flag stays set until `rst` or `hw_stby`. Register writes and `sw_stby` do not clear it.
- R9: If a set event and a write occur in the same cycle, the flag sets and bits 6..0 take the written value.
- R10: While `flash_en` is low, `rdata` reads 0x00. The stored contents return unchanged once `flash_en` is high again.
- R11: A cycle with `sw_stby` high clears bits 6..0, overrides a write in the same cycle, and leaves the flag as it was.
- R12: `protect` equals the flag delayed by one cycle. `pe_req_out` equals `pe_req_in` while `protect` is 0, and is 0 while `protect` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (pin or watchdog) |
| hw_stby | input | 1 | Hardware standby; clears the whole register |
| sw_stby | input | 1 | Software standby; clears bits 6..0 |
| flash_en | input | 1 | On-chip flash enabled; 0 forces reads to zero |
| reg_we | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pe_active | input | 1 | Program or erase operation in progress |
| rd_strobe | input | 1 | Flash read (data, vector or fetch) |
| rd_ram_overlap | input | 1 | The read targets RAM overlapping flash space |
| exc_start | input | 1 | Exception handling starts |
| exc_code | input | 3 | Exception type code |
| sleep_exec | input | 1 | Sleep instruction executes |
| bus_release | input | 1 | Bus released to another master |
| pe_req_in | input | 1 | Program/erase-enable request from control logic |
| pe_req_out | output | 1 | Gated program/erase-enable request |
| protect | output | 1 | Error-protection state |

## Verification
A flag that sets wrongly shows on `rdata[7]` two cycles after the event. It also raises `protect` in the same cycle and drops `pe_req_out`. A flag that fails to set or clear shows up in the same way.

Corrupted reserved storage appears on `rdata[6:0]` at the next read, unless `flash_en` is low. In that case the fault hides until the flash is enabled again. Every exception code and every combination of read qualifier and active flag is swept, each from a fresh reset, so a qualification error cannot be masked by a flag left over from an earlier step.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int DATA_W = 8;
  localparam int RSV_W  = DATA_W - 1;

  typedef enum int {
    CAUSE_READ  = 0,
    CAUSE_EXC   = 1,
    CAUSE_SLEEP = 2,
    CAUSE_BUS   = 3
  } cause_e;
  localparam int N_CAUSE = 4;
endpackage

// File: rtl/fe_event_qual.sv
module fe_event_qual
  import fe_pkg::*;
#(
  parameter int EXC_W = 3,
  parameter logic [2**EXC_W-1:0] EXEMPT_MASK = 'hF
) (
  input  logic             pe_active,
  input  logic             rd_strobe,
  input  logic             rd_ram_overlap,
  input  logic             exc_start,
  input  logic [EXC_W-1:0] exc_code,
  input  logic             sleep_exec,
  input  logic             bus_release,
  output logic             set_evt
);
  logic [N_CAUSE-1:0] cause;
  logic               exc_counts;

  // An exception only counts when its code is not in the exempt set
  assign exc_counts = ~EXEMPT_MASK[exc_code];

  always_comb begin
    cause              = '0;
    cause[CAUSE_READ]  = rd_strobe & ~rd_ram_overlap;
    cause[CAUSE_EXC]   = exc_start & exc_counts;
    cause[CAUSE_SLEEP] = sleep_exec;
    cause[CAUSE_BUS]   = bus_release;
  end

  assign set_evt = pe_active & (|cause);
endmodule

// File: rtl/fe_status_reg.sv
module fe_status_reg
  import fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             reg_we,
  input  logic [RSV_W-1:0] wdata_rsv,
  input  logic             set_evt,
  output logic             err_q,
  output logic [RSV_W-1:0] rsv_q,
  output logic             protect_q
);
  always_ff @(posedge clk) begin
    if (rst || hw_stby) begin
      err_q     <= 1'b0;
      rsv_q     <= '0;
      protect_q <= 1'b0;
    end else begin
      err_q     <= err_q | set_evt;
      protect_q <= err_q;
      if (sw_stby)     rsv_q <= '0;
      else if (reg_we) rsv_q <= wdata_rsv;
    end
  end
endmodule

// File: rtl/fe_read_port.sv
module fe_read_port
  import fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic              flash_en,
  input  logic              err_q,
  input  logic [RSV_W-1:0]  rsv_q,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst || hw_stby || !flash_en) rdata <= '0;
    else                            rdata <= {err_q, rsv_q};
  end
endmodule

// File: rtl/flash_err_guard.sv
module flash_err_guard
  import fe_pkg::*;
#(
  parameter int EXC_W = 3,
  parameter logic [2**EXC_W-1:0] EXEMPT_MASK = 'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              flash_en,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pe_active,
  input  logic              rd_strobe,
  input  logic              rd_ram_overlap,
  input  logic              exc_start,
  input  logic [EXC_W-1:0]  exc_code,
  input  logic              sleep_exec,
  input  logic              bus_release,
  input  logic              pe_req_in,
  output logic              pe_req_out,
  output logic              protect
);
  logic             set_evt;
  logic             err_flag;
  logic [RSV_W-1:0] rsv_bits;

  fe_event_qual #(.EXC_W(EXC_W), .EXEMPT_MASK(EXEMPT_MASK)) u_qual (
    .pe_active      (pe_active),
    .rd_strobe      (rd_strobe),
    .rd_ram_overlap (rd_ram_overlap),
    .exc_start      (exc_start),
    .exc_code       (exc_code),
    .sleep_exec     (sleep_exec),
    .bus_release    (bus_release),
    .set_evt        (set_evt)
  );

  fe_status_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .reg_we    (reg_we),
    .wdata_rsv (wdata[RSV_W-1:0]),
    .set_evt   (set_evt),
    .err_q     (err_flag),
    .rsv_q     (rsv_bits),
    .protect_q (protect)
  );

  fe_read_port u_rd (
    .clk      (clk),
    .rst      (rst),
    .hw_stby  (hw_stby),
    .flash_en (flash_en),
    .err_q    (err_flag),
    .rsv_q    (rsv_bits),
    .rdata    (rdata)
  );

  assign pe_req_out = pe_req_in & ~protect;
endmodule

// File: rtl/flash_err_guard_chk.sv
module flash_err_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       hw_stby,
  input logic       flash_en,
  input logic       pe_active,
  input logic       bus_release,
  input logic       err_flag,
  input logic       protect,
  input logic       pe_req_out,
  input logic [7:0] rdata
);
  AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> (!err_flag && !protect)); // R1

  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!pe_active && !err_flag && !hw_stby) |=> !err_flag); // R7

  AST_BUS_SETS: assert property (@(posedge clk) disable iff (rst)
    (pe_active && bus_release && !hw_stby) |=> err_flag); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !hw_stby) |=> err_flag); // R8

  AST_DISABLED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !flash_en |=> (rdata == 8'h00)); // R10

  AST_PROTECT_LAGS: assert property (@(posedge clk) disable iff (rst)
    (!hw_stby && !err_flag) |=> !protect); // R12

  AST_GATE_REQ: assert property (@(posedge clk) disable iff (rst)
    protect |-> !pe_req_out); // R12
endmodule

bind flash_err_guard flash_err_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .hw_stby     (hw_stby),
  .flash_en    (flash_en),
  .pe_active   (pe_active),
  .bus_release (bus_release),
  .err_flag    (err_flag),
  .protect     (protect),
  .pe_req_out  (pe_req_out),
  .rdata       (rdata)
);

// File: tb/flash_err_guard_bench.sv
module flash_err_guard_bench;
  logic       clk = 1'b0;
  logic       rst, hw_stby, sw_stby, flash_en, reg_we;
  logic [7:0] wdata, rdata;
  logic       pe_active, rd_strobe, rd_ram_overlap, exc_start;
  logic [2:0] exc_code;
  logic       sleep_exec, bus_release, pe_req_in, pe_req_out, protect;
  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  flash_err_guard u_flash_err_guard (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .flash_en(flash_en), .reg_we(reg_we), .wdata(wdata), .rdata(rdata),
    .pe_active(pe_active), .rd_strobe(rd_strobe), .rd_ram_overlap(rd_ram_overlap),
    .exc_start(exc_start), .exc_code(exc_code), .sleep_exec(sleep_exec),
    .bus_release(bus_release), .pe_req_in(pe_req_in), .pe_req_out(pe_req_out),
    .protect(protect)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    reg_we = 0; rd_strobe = 0; rd_ram_overlap = 0; exc_start = 0;
    sleep_exec = 0; bus_release = 0; sw_stby = 0; hw_stby = 0;
  endtask

  task automatic do_reset();
    quiet(); pe_active = 0; rst = 1; tick(); rst = 0; tick();
  endtask

  task automatic set_flag();
    pe_active = 1; bus_release = 1; tick(); bus_release = 0; pe_active = 0; tick();
  endtask

  initial begin
    rst = 1; flash_en = 1; pe_req_in = 1; wdata = 0; exc_code = 0; pe_active = 0;
    quiet();
    repeat (3) tick();
    rst = 0; tick();
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset protect", {7'd0, protect}, 8'h00);
    chk("R12 request passes", {7'd0, pe_req_out}, 8'h01);

    // R2 / R3: every reserved pattern, bit 7 driven by the low bit
    for (int v = 0; v < 128; v++) begin
      wdata = {v[0], v[6:0]}; reg_we = 1; tick(); reg_we = 0; tick();
      chk("R2/R3 reserved write", rdata, {1'b0, v[6:0]});
    end

    // R5 / R7: exception codes with and without an operation running
    for (int pe = 0; pe < 2; pe++)
      for (int c = 0; c < 8; c++) begin
        do_reset();
        pe_active = pe[0]; exc_start = 1; exc_code = c[2:0]; tick();
        exc_start = 0; pe_active = 0; tick();
        chk("R5/R7 exception", rdata, {(pe == 1 && c >= 4), 7'd0});
      end

    // R4 / R7: read with overlap qualifier
    for (int pe = 0; pe < 2; pe++)
      for (int ov = 0; ov < 2; ov++) begin
        do_reset();
        pe_active = pe[0]; rd_strobe = 1; rd_ram_overlap = ov[0]; tick();
        quiet(); pe_active = 0; tick();
        chk("R4/R7 flash read", rdata, {(pe == 1 && ov == 0), 7'd0});
      end

    // R6 / R7: sleep and bus release
    for (int pe = 0; pe < 2; pe++)
      for (int k = 0; k < 2; k++) begin
        do_reset();
        pe_active = pe[0]; sleep_exec = (k == 0); bus_release = (k == 1); tick();
        quiet(); pe_active = 0; tick();
        chk("R6/R7 sleep or bus release", rdata, {(pe == 1), 7'd0});
      end

    // R12: protect lags the flag by one cycle and gates the request
    do_reset();
    pe_active = 1; bus_release = 1; tick(); quiet(); pe_active = 0;
    chk("R12 protect still low", {7'd0, protect}, 8'h00);
    tick();
    chk("R12 protect high", {7'd0, protect}, 8'h01);
    chk("R12 request gated", {7'd0, pe_req_out}, 8'h00);

    // R8: writes do not clear the flag
    wdata = 8'h00; reg_we = 1; tick(); reg_we = 0; tick();
    chk("R8 sticky after write", rdata, 8'h80);

    // R1: hardware standby clears everything
    hw_stby = 1; tick(); hw_stby = 0; tick();
    chk("R1 hw standby rdata", rdata, 8'h00);
    chk("R1 hw standby protect", {7'd0, protect}, 8'h00);

    // R9: set and write in the same cycle
    do_reset();
    pe_active = 1; bus_release = 1; reg_we = 1; wdata = 8'h55; tick();
    quiet(); pe_active = 0; tick();
    chk("R9 set and write together", rdata, 8'hD5);

    // R10: disabled flash reads zero, state retained
    wdata = 8'h2A; reg_we = 1; tick(); reg_we = 0;
    flash_en = 0; tick(); tick();
    chk("R10 disabled reads zero", rdata, 8'h00);
    flash_en = 1; tick(); tick();
    chk("R10 contents kept", rdata, 8'hAA);

    // R11: software standby clears reserved bits, keeps flag, beats a write
    sw_stby = 1; reg_we = 1; wdata = 8'h7F; tick(); quiet(); tick();
    chk("R11 sw standby", rdata, 8'h80);
    do_reset();
    wdata = 8'h33; reg_we = 1; tick(); reg_we = 0;
    sw_stby = 1; tick(); sw_stby = 0; tick();
    chk("R11 sw standby flag clear", rdata, 8'h00);

    // R1: reset clears a set flag
    set_flag();
    chk("R8 flag set before reset", rdata, 8'h80);
    rst = 1; tick(); rst = 0; tick();
    chk("R1 reset clears flag", rdata, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule